// File: doc/BRIEF.md
# PCI Power-Management Control/Status Register

This block holds the 16-bit power-management control and status word of a PCI function, together with the read-only extension word that sits beside it. Configuration software reads and writes it through a simple word-wide access port with an address, two byte-lane enables, write data, a write strobe and a read strobe. Read data comes back from a register one cycle after the read strobe.

An internal wake event latches a sticky status flag whether or not wake signalling is enabled. The PME output is the registered AND of that flag and an enable bit. Software clears the flag, and with it the PME output, by writing a one to it. A two-bit field selects the function's power state and drives the `pwr_state` output. The field encodings follow the usual D0 to D3 numbering.

Two resets reach the block. The global reset clears every stored bit. The function reset is raised inside the chip when the function returns from D3hot to D0. It only clears the read-data register and leaves the status, enable and power-state bits untouched. All unimplemented fields read as zero and ignore writes.

Top module: `pm_csr_block`

## Requirements
- R1: After the global reset, offset 48h reads 0000h, `pme_o` is 0 and `pwr_state` is 00.
- R2: A cycle with `wake_evt` high sets bit 15 of the word at 48h, whatever the value of the enable bit 8.
- R3: A write to 48h with byte lane 1 enabled and data bit 15 = 1 clears bit 15 and drops `pme_o`. Data bit 15 = 0 leaves bit 15 unchanged.
- R4: When a wake event and a clearing write to bit 15 arrive in the same cycle, bit 15 ends up set.
- R5: `pme_o` is high exactly when bit 15 and bit 8 are both 1. It is updated on the same clock edge as those bits, so with bit 8 = 0 it stays low.
- R6: Bits 1:0 are read/write and hold the power state, with 00=D0, 01=D1, 10=D2 and 11=D3. Their value appears on `pwr_state`.
- R7: `cfg_be[1]` gates every change to bits 15 and 8, and `cfg_be[0]` gates every change to bits 1:0.
- R8: Bits 14:9 and 7:2 at 48h always read 0, and writing them has no effect.
- R9: Offset 4Ah always reads 0000h and writes to it change nothing. Any address other than 48h and 4Ah reads 0000h.
- R10: `cfg_rdata` carries the addressed word in the cycle after `cfg_re` is high, and 0000h in every other cycle.
- R11: `func_rst` leaves bits 15, 8 and 1:0 and the outputs `pme_o` and `pwr_state` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst | input | 1 | Global reset, synchronous, active high |
| func_rst | input | 1 | Function reset raised on D3hot-to-D0 return, synchronous, active high |
| cfg_addr | input | ADDR_W (8) | Configuration byte address of the word |
| cfg_be | input | 2 | Byte-lane enables: bit 0 covers data bits 7:0, bit 1 covers data bits 15:8 |
| cfg_wdata | input | 16 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | 16 | Registered read data |
| wake_evt | input | 1 | Internal wake event, one cycle per event |
| pme_o | output | 1 | Registered PME request |
| pwr_state | output | 2 | Current power state |

## Verification
Wake events are applied with the enable bit both clear and set. This separates latching of the status bit from gating of `pme_o`. Clearing writes are made with data bit 15 at 0 and at 1, with only one byte lane and with both, and in the same cycle as a wake event. These cases tell write-one-to-clear apart from plain writes, and show whether the lanes and the set-over-clear priority are honoured. All-ones writes to 48h, to 4Ah and to an unmapped address expose any stored reserved bit or stray decode. A function-reset pulse taken with every field non-zero shows whether the sticky bits sit in the wrong reset domain.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned LANES     = WORD_W / 8;
  localparam int unsigned STATE_W   = 2;
  localparam int unsigned STS_BIT   = 15;
  localparam int unsigned EN_BIT    = 8;
  localparam int unsigned CSR_OFS   = 'h48;
  localparam int unsigned EXT_OFS   = 'h4A;

  typedef enum logic [STATE_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;
endpackage

// File: rtl/pm_wake_latch.sv
module pm_wake_latch (
  input  logic clk,
  input  logic grst,
  input  logic wake_evt,
  input  logic clr_req,
  input  logic en_next,
  output logic sts_q,
  output logic pme_q
);
  logic sts_next;

  // set takes priority over clear so no event is lost
  assign sts_next = wake_evt | (sts_q & ~clr_req);

  always_ff @(posedge clk) begin
    if (grst) begin
      sts_q <= 1'b0;
      pme_q <= 1'b0;
    end else begin
      sts_q <= sts_next;
      pme_q <= sts_next & en_next;
    end
  end
endmodule

// File: rtl/pm_ctrl_fields.sv
module pm_ctrl_fields
  import pm_csr_pkg::*;
(
  input  logic               clk,
  input  logic               grst,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic               en_wdata,
  input  logic [STATE_W-1:0] state_wdata,
  output logic               en_next,
  output logic               en_q,
  output pstate_e            state_q
);
  assign en_next = wr_hi ? en_wdata : en_q;

  always_ff @(posedge clk) begin
    if (grst) begin
      en_q    <= 1'b0;
      state_q <= PS_D0;
    end else begin
      en_q <= en_next;
      if (wr_lo) state_q <= pstate_e'(state_wdata);
    end
  end
endmodule

// File: rtl/pm_read_port.sv
module pm_read_port
  import pm_csr_pkg::*;
(
  input  logic              clk,
  input  logic              grst,
  input  logic              func_rst,
  input  logic              rd_en,
  input  logic              hit_csr,
  input  logic              sts,
  input  logic              en,
  input  logic [STATE_W-1:0] state,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] csr_word;

  always_comb begin
    csr_word = '0;
    csr_word[STS_BIT]       = sts;
    csr_word[EN_BIT]        = en;
    csr_word[STATE_W-1:0]   = state;
  end

  always_ff @(posedge clk) begin
    if (grst || func_rst)
      rdata <= '0;
    else if (rd_en && hit_csr)
      rdata <= csr_word;
    else
      rdata <= '0;
  end
endmodule

// File: rtl/pm_csr_block.sv
module pm_csr_block
  import pm_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic               clk,
  input  logic               grst,
  input  logic               func_rst,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [LANES-1:0]   cfg_be,
  input  logic [WORD_W-1:0]  cfg_wdata,
  input  logic               cfg_we,
  input  logic               cfg_re,
  output logic [WORD_W-1:0]  cfg_rdata,
  input  logic               wake_evt,
  output logic               pme_o,
  output logic [STATE_W-1:0] pwr_state
);
  localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_OFS);
  localparam logic [ADDR_W-1:0] EXT_A = ADDR_W'(EXT_OFS);

  logic    hit_csr, hit_ext;
  logic    wr_hi, wr_lo, clr_req;
  logic    en_next, en_q, sts_q;
  pstate_e state_q;
  logic    unused_bits;

  assign hit_csr = (cfg_addr == CSR_A);
  assign hit_ext = (cfg_addr == EXT_A);
  assign wr_hi   = cfg_we & hit_csr & cfg_be[1];
  assign wr_lo   = cfg_we & hit_csr & cfg_be[0];
  assign clr_req = wr_hi & cfg_wdata[STS_BIT];
  assign unused_bits = ^{cfg_wdata[14:9], cfg_wdata[7:2], hit_ext};

  pm_ctrl_fields u_ctrl (
    .clk         (clk),
    .grst        (grst),
    .wr_hi       (wr_hi),
    .wr_lo       (wr_lo),
    .en_wdata    (cfg_wdata[EN_BIT]),
    .state_wdata (cfg_wdata[STATE_W-1:0]),
    .en_next     (en_next),
    .en_q        (en_q),
    .state_q     (state_q)
  );

  pm_wake_latch u_wake (
    .clk      (clk),
    .grst     (grst),
    .wake_evt (wake_evt),
    .clr_req  (clr_req),
    .en_next  (en_next),
    .sts_q    (sts_q),
    .pme_q    (pme_o)
  );

  // the extension word at 4Ah reads zero, same as unmapped addresses
  pm_read_port u_rd (
    .clk      (clk),
    .grst     (grst),
    .func_rst (func_rst),
    .rd_en    (cfg_re),
    .hit_csr  (hit_csr),
    .sts      (sts_q),
    .en       (en_q),
    .state    (state_q),
    .rdata    (cfg_rdata)
  );

  assign pwr_state = state_q;
endmodule

// File: rtl/pm_csr_checker.sv
module pm_csr_checker (
  input logic        clk,
  input logic        grst,
  input logic        func_rst,
  input logic [7:0]  cfg_addr,
  input logic [1:0]  cfg_be,
  input logic [15:0] cfg_wdata,
  input logic        cfg_we,
  input logic        cfg_re,
  input logic [15:0] cfg_rdata,
  input logic        wake_evt,
  input logic        pme_o,
  input logic [1:0]  pwr_state,
  input logic        sts,
  input logic        en
);
  logic clr_hit;
  assign clr_hit = cfg_we && cfg_addr == 8'h48 && cfg_be[1] && cfg_wdata[15];

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (grst)
    wake_evt |=> sts);  // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (grst)
    (clr_hit && !wake_evt) |=> (!sts && !pme_o));  // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (grst)
    (clr_hit && wake_evt) |=> sts);  // R4

  AST_PME_GATED: assert property (@(posedge clk) disable iff (grst)
    pme_o |-> (sts && en));  // R5

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (grst)
    (cfg_rdata[14:9] == 6'd0) && (cfg_rdata[7:2] == 6'd0));  // R8

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (grst)
    !cfg_re |=> (cfg_rdata == 16'h0000));  // R10

  AST_FRST_KEEPS: assert property (@(posedge clk) disable iff (grst)
    (func_rst && !cfg_we && !wake_evt) |=> ($stable(pwr_state) && $stable(en) && $stable(sts)));  // R11
endmodule

bind pm_csr_block pm_csr_checker u_chk (
  .clk       (clk),
  .grst      (grst),
  .func_rst  (func_rst),
  .cfg_addr  (cfg_addr),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .cfg_we    (cfg_we),
  .cfg_re    (cfg_re),
  .cfg_rdata (cfg_rdata),
  .wake_evt  (wake_evt),
  .pme_o     (pme_o),
  .pwr_state (pwr_state),
  .sts       (sts_q),
  .en        (en_q)
);

// File: tb/tb_pm_csr_block.sv
module tb_pm_csr_block;
  logic        clk = 1'b0;
  logic        grst, func_rst;
  logic [7:0]  cfg_addr;
  logic [1:0]  cfg_be;
  logic [15:0] cfg_wdata;
  logic        cfg_we, cfg_re;
  logic [15:0] cfg_rdata;
  logic        wake_evt, pme_o;
  logic [1:0]  pwr_state;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        re_d = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pm_csr_block dut (
    .clk(clk), .grst(grst), .func_rst(func_rst), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_rdata(cfg_rdata), .wake_evt(wake_evt), .pme_o(pme_o), .pwr_state(pwr_state)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%04h expected=%04h", tag, act, expv);
    end
  endtask

  // driver: one access per cycle, driven at negedge
  task automatic cyc(logic we, logic [7:0] a, logic [1:0] be, logic [15:0] d, logic wk);
    cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = d; wake_evt = wk;
    @(negedge clk);
    cfg_we = 1'b0; wake_evt = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [15:0] expv, string tag);
    cfg_re = 1'b1; cfg_addr = a;
    exp_q.push_back(expv); tag_q.push_back(tag);
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  // monitor: compares read data in the cycle after each read strobe
  always @(posedge clk) re_d <= cfg_re;
  always @(negedge clk) begin
    if (re_d && exp_q.size() > 0) begin
      check(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    grst = 1'b1; func_rst = 1'b0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0;
    cfg_we = 1'b0; cfg_re = 1'b0; wake_evt = 1'b0;
    repeat (3) @(negedge clk);
    grst = 1'b0;
    check("R1 pme", {15'd0, pme_o}, 16'h0);
    check("R1 state", {14'd0, pwr_state}, 16'h0);
    rd(8'h48, 16'h0000, "R1 word");
    check("R10 idle", cfg_rdata, 16'h0);  // monitor consumed; now check again next cycle
    @(negedge clk);
    check("R10 idle rdata", cfg_rdata, 16'h0000);

    cyc(1'b0, 8'h48, 2'b00, 16'h0, 1'b1);
    check("R5 disabled pme", {15'd0, pme_o}, 16'h0);
    rd(8'h48, 16'h8000, "R2 wake with enable off");

    cyc(1'b1, 8'h48, 2'b11, 16'h0100, 1'b0);
    check("R5 pme on", {15'd0, pme_o}, 16'h1);
    rd(8'h48, 16'h8100, "R3 zero write keeps status");

    cyc(1'b1, 8'h48, 2'b01, 16'h8000, 1'b0);
    rd(8'h48, 16'h8100, "R7 lower lane leaves upper bits");

    cyc(1'b1, 8'h48, 2'b11, 16'hFFFF, 1'b0);
    check("R3 pme cleared", {15'd0, pme_o}, 16'h0);
    check("R6 state D3", {14'd0, pwr_state}, 16'h3);
    rd(8'h48, 16'h0103, "R8 reserved ignore ones");

    cyc(1'b0, 8'h48, 2'b00, 16'h0, 1'b1);
    check("R5 pme after wake", {15'd0, pme_o}, 16'h1);
    cyc(1'b1, 8'h48, 2'b10, 16'h8103, 1'b1);
    check("R4 pme held", {15'd0, pme_o}, 16'h1);
    rd(8'h48, 16'h8103, "R4 set wins");

    cyc(1'b1, 8'h48, 2'b10, 16'h8003, 1'b0);
    check("R3 pme low", {15'd0, pme_o}, 16'h0);
    rd(8'h48, 16'h0003, "R3 clear and disable");

    cyc(1'b1, 8'h48, 2'b01, 16'h0002, 1'b0);
    check("R6 state D2", {14'd0, pwr_state}, 16'h2);
    cyc(1'b1, 8'h48, 2'b10, 16'h0001, 1'b0);
    check("R7 upper lane keeps state", {14'd0, pwr_state}, 16'h2);

    cyc(1'b1, 8'h4A, 2'b11, 16'hFFFF, 1'b0);
    rd(8'h4A, 16'h0000, "R9 ext reads zero");
    rd(8'h48, 16'h0002, "R9 ext write no effect");
    cyc(1'b1, 8'h50, 2'b11, 16'hFFFF, 1'b0);
    rd(8'h50, 16'h0000, "R9 unmapped reads zero");
    rd(8'h48, 16'h0002, "R9 unmapped write no effect");

    cyc(1'b0, 8'h48, 2'b00, 16'h0, 1'b1);
    cyc(1'b1, 8'h48, 2'b10, 16'h0100, 1'b0);
    check("R5 pme after enable", {15'd0, pme_o}, 16'h1);
    func_rst = 1'b1;
    repeat (2) @(negedge clk);
    func_rst = 1'b0;
    check("R11 pme kept", {15'd0, pme_o}, 16'h1);
    check("R11 state kept", {14'd0, pwr_state}, 16'h2);
    rd(8'h48, 16'h8102, "R11 word kept");

    grst = 1'b1;
    @(negedge clk);
    grst = 1'b0;
    check("R1 pme after grst", {15'd0, pme_o}, 16'h0);
    rd(8'h48, 16'h0000, "R1 word after grst");
    @(negedge clk);
    check("R10 queue drained", 16'(exp_q.size()), 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule